// File: doc/BRIEF.md
# Snapshot Timer Counter Unit

This block is one counting unit of a system timer: a free-running 52-bit up-counter that advances on a qualified tick. Software never reads the live count directly. It raises an update strobe, waits for a valid flag, and then reads a 20-bit upper word and a 32-bit lower word that were captured together in a single cycle. So the two halves always describe the same count value.

The count can be preset. Software first writes an upper and a lower preload word into holding registers, which leaves the count untouched. A separate load strobe then copies both words into the counter. A run bit gates counting. Two stall inputs, one per processor core, can each freeze the count, but only when that core's mask bit is set. The block is built twice with different reset defaults for the run bit and the stall masks. Everything runs on one clock.

Top module: `snap_timer_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `snap_valid` is 0 and both snapshot words are 0. `cfg_run_q` and `cfg_mask_q` show the parameter defaults: run 1 and mask 2'b00 for the default (unit 0) build, and run 0 and mask 2'b11 for the unit 1 build. The internal count resets to 0.
- R2: The count rises by exactly one for each clock edge where `tick_en` is 1, the run bit is 1 and no masked stall is active.
- R3: On an edge where `tick_en` is 0, the count keeps its value.
- R4: While the run bit is 0, written through `cfg_wr` with `cfg_run_in`, the count keeps its value even with `tick_en` high.
- R5: Bit c of `cfg_mask_q` (c = 0 or 1) lets `core_stall[c]` freeze the count. A stall on a core whose mask bit is 0 has no effect.
- R6: `ld_hi_wr` and `ld_lo_wr` update only the preload holding words and leave the count unchanged.
- R7: On an edge where `load_go` is 1, the count becomes {upper preload word, lower preload word}. This replaces any increment on the same edge.
- R8: `upd_go` sampled at edge E clears `snap_valid` after E. After edge E+1, `snap_valid` is 1, and `snap_hi`/`snap_lo` hold bits 51:32 and 31:0 of the count that was present between E and E+1. The snapshot words then stay stable while `snap_valid` stays 1.
- R9: The 52-bit count carries from bit 31 into bit 32 and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count qualifier for this cycle |
| core_stall | input | 2 | Per-core stall indication |
| cfg_wr | input | 1 | Write strobe for run bit and stall mask |
| cfg_run_in | input | 1 | Run bit value to write |
| cfg_mask_in | input | 2 | Stall mask value to write |
| cfg_run_q | output | 1 | Current run bit |
| cfg_mask_q | output | 2 | Current stall mask |
| ld_hi_wr | input | 1 | Write strobe for upper preload word |
| ld_hi_data | input | 20 | Upper preload word data |
| ld_lo_wr | input | 1 | Write strobe for lower preload word |
| ld_lo_data | input | 32 | Lower preload word data |
| load_go | input | 1 | Copy preload words into the count |
| upd_go | input | 1 | Request a snapshot of the count |
| snap_valid | output | 1 | Snapshot captured and readable |
| snap_hi | output | 20 | Snapshot bits 51:32 |
| snap_lo | output | 32 | Snapshot bits 31:0 |

## Verification
Configuration, preload and load strobes take effect at the edge that samples them. A snapshot becomes readable two edges after its request, and the valid flag drops after the first of those two edges. The bench drives every input half a period before an edge, holds `tick_en` low around each snapshot request so the expected count is exact, and checks the dropped flag one edge after the request. A monitor compares the queued expected value on the rising edge of the valid flag, so every comparison falls in the cycle where the value is due.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;

    localparam int CNT_W = 52;
    localparam int LO_W  = 32;
    localparam int HI_W  = CNT_W - LO_W;
    localparam int NCORE = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [HI_W-1:0]  hi_t;
    typedef logic [LO_W-1:0]  lo_t;

    typedef struct packed {
        logic             run;
        logic [NCORE-1:0] stall_mask;
    } unit_cfg_t;

    function automatic cnt_t join_words(input hi_t hi, input lo_t lo);
        return {hi, lo};
    endfunction

    function automatic hi_t upper_of(input cnt_t v);
        return v[CNT_W-1:LO_W];
    endfunction

    function automatic lo_t lower_of(input cnt_t v);
        return v[LO_W-1:0];
    endfunction

endpackage

// File: rtl/stp_cfg_regs.sv
module stp_cfg_regs
    import snap_timer_pkg::*;
#(
    parameter logic             RUN_RST  = 1'b1,
    parameter logic [NCORE-1:0] MASK_RST = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  unit_cfg_t cfg_in,
    input  logic      ld_hi_wr,
    input  hi_t       ld_hi_data,
    input  logic      ld_lo_wr,
    input  lo_t       ld_lo_data,
    output unit_cfg_t cfg_q,
    output cnt_t      load_word
);

    hi_t pre_hi;
    lo_t pre_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.run        <= RUN_RST;
            cfg_q.stall_mask <= MASK_RST;
        end else if (cfg_wr) begin
            cfg_q <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_hi <= '0;
            pre_lo <= '0;
        end else begin
            if (ld_hi_wr) pre_hi <= ld_hi_data;
            if (ld_lo_wr) pre_lo <= ld_lo_data;
        end
    end

    assign load_word = join_words(pre_hi, pre_lo);

endmodule

// File: rtl/stp_counter.sv
module stp_counter
    import snap_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  unit_cfg_t        cfg,
    input  logic             tick_en,
    input  logic [NCORE-1:0] core_stall,
    input  logic             load_go,
    input  cnt_t             load_word,
    output cnt_t             cnt_q
);

    logic [NCORE-1:0] freeze_vec;
    logic             step;

    for (genvar c = 0; c < NCORE; c++) begin : g_stall
        assign freeze_vec[c] = core_stall[c] & cfg.stall_mask[c];
    end

    assign step = tick_en & cfg.run & ~(|freeze_vec);

    // the load has priority over an increment on the same edge
    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (load_go) cnt_q <= load_word;
        else if (step)    cnt_q <= cnt_q + cnt_t'(1);
    end

endmodule

// File: rtl/stp_snapshot.sv
module stp_snapshot
    import snap_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd_go,
    input  cnt_t cnt,
    output logic snap_valid,
    output hi_t  snap_hi,
    output lo_t  snap_lo
);

    typedef enum logic {SNAP_IDLE, SNAP_GRAB} snap_state_t;
    snap_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SNAP_IDLE;
            snap_valid <= 1'b0;
            snap_hi    <= '0;
            snap_lo    <= '0;
        end else if (upd_go) begin
            state      <= SNAP_GRAB;
            snap_valid <= 1'b0;
        end else if (state == SNAP_GRAB) begin
            // both words captured on one edge
            snap_hi    <= upper_of(cnt);
            snap_lo    <= lower_of(cnt);
            snap_valid <= 1'b1;
            state      <= SNAP_IDLE;
        end
    end

endmodule

// File: rtl/snap_timer_unit.sv
module snap_timer_unit
    import snap_timer_pkg::*;
#(
    parameter logic             RUN_RST  = 1'b1,
    parameter logic [NCORE-1:0] MASK_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [NCORE-1:0] core_stall,
    input  logic             cfg_wr,
    input  logic             cfg_run_in,
    input  logic [NCORE-1:0] cfg_mask_in,
    output logic             cfg_run_q,
    output logic [NCORE-1:0] cfg_mask_q,
    input  logic             ld_hi_wr,
    input  logic [HI_W-1:0]  ld_hi_data,
    input  logic             ld_lo_wr,
    input  logic [LO_W-1:0]  ld_lo_data,
    input  logic             load_go,
    input  logic             upd_go,
    output logic             snap_valid,
    output logic [HI_W-1:0]  snap_hi,
    output logic [LO_W-1:0]  snap_lo
);

    unit_cfg_t cfg_in_s;
    unit_cfg_t cfg_s;
    cnt_t      load_word;
    cnt_t      cnt_q;

    assign cfg_in_s.run        = cfg_run_in;
    assign cfg_in_s.stall_mask = cfg_mask_in;
    assign cfg_run_q           = cfg_s.run;
    assign cfg_mask_q          = cfg_s.stall_mask;

    stp_cfg_regs #(
        .RUN_RST (RUN_RST),
        .MASK_RST(MASK_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_in    (cfg_in_s),
        .ld_hi_wr  (ld_hi_wr),
        .ld_hi_data(ld_hi_data),
        .ld_lo_wr  (ld_lo_wr),
        .ld_lo_data(ld_lo_data),
        .cfg_q     (cfg_s),
        .load_word (load_word)
    );

    stp_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_s),
        .tick_en   (tick_en),
        .core_stall(core_stall),
        .load_go   (load_go),
        .load_word (load_word),
        .cnt_q     (cnt_q)
    );

    stp_snapshot u_snap (
        .clk       (clk),
        .rst       (rst),
        .upd_go    (upd_go),
        .cnt       (cnt_q),
        .snap_valid(snap_valid),
        .snap_hi   (snap_hi),
        .snap_lo   (snap_lo)
    );

endmodule

// File: rtl/stp_checker.sv
module stp_checker
    import snap_timer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             load_go,
    input logic             upd_go,
    input logic [NCORE-1:0] core_stall,
    input logic [NCORE-1:0] stall_mask,
    input cnt_t             cnt_q,
    input cnt_t             load_word,
    input logic             snap_valid,
    input hi_t              snap_hi,
    input lo_t              snap_lo
);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(load_go) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + cnt_t'(1))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick_en) && !$past(load_go)) |-> $stable(cnt_q)); // R3

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        ($past(|(core_stall & stall_mask)) && !$past(load_go)) |-> $stable(cnt_q)); // R5

    AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (rst)
        $past(load_go) |-> cnt_q == $past(load_word)); // R7

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        upd_go |=> !snap_valid); // R8

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_go) && !upd_go) |=> snap_valid); // R8

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (snap_valid && $past(snap_valid)) |-> ($stable(snap_hi) && $stable(snap_lo))); // R8

endmodule

bind snap_timer_unit stp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .load_go   (load_go),
    .upd_go    (upd_go),
    .core_stall(core_stall),
    .stall_mask(cfg_mask_q),
    .cnt_q     (cnt_q),
    .load_word (load_word),
    .snap_valid(snap_valid),
    .snap_hi   (snap_hi),
    .snap_lo   (snap_lo)
);

// File: tb/snap_timer_unit_test.sv
`timescale 1ns/1ps
module snap_timer_unit_test;
    import snap_timer_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic [NCORE-1:0] core_stall = '0;
    logic cfg_wr = 1'b0;
    logic cfg_run_in = 1'b0;
    logic [NCORE-1:0] cfg_mask_in = '0;
    logic ld_hi_wr = 1'b0;
    logic [HI_W-1:0] ld_hi_data = '0;
    logic ld_lo_wr = 1'b0;
    logic [LO_W-1:0] ld_lo_data = '0;
    logic load_go = 1'b0;
    logic upd_go = 1'b0;

    logic cfg_run_q, cfg_run_q_b;
    logic [NCORE-1:0] cfg_mask_q, cfg_mask_q_b;
    logic snap_valid, snap_valid_b;
    logic [HI_W-1:0] snap_hi, snap_hi_b;
    logic [LO_W-1:0] snap_lo, snap_lo_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    cnt_t exp_q[$];
    cnt_t exp_cnt = '0;

    always #2.5 clk = ~clk;

    snap_timer_unit uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .core_stall(core_stall),
        .cfg_wr(cfg_wr), .cfg_run_in(cfg_run_in), .cfg_mask_in(cfg_mask_in),
        .cfg_run_q(cfg_run_q), .cfg_mask_q(cfg_mask_q),
        .ld_hi_wr(ld_hi_wr), .ld_hi_data(ld_hi_data),
        .ld_lo_wr(ld_lo_wr), .ld_lo_data(ld_lo_data),
        .load_go(load_go), .upd_go(upd_go),
        .snap_valid(snap_valid), .snap_hi(snap_hi), .snap_lo(snap_lo)
    );

    snap_timer_unit #(.RUN_RST(1'b0), .MASK_RST(2'b11)) uut_b (
        .clk(clk), .rst(rst), .tick_en(1'b0), .core_stall(2'b00),
        .cfg_wr(1'b0), .cfg_run_in(1'b0), .cfg_mask_in(2'b00),
        .cfg_run_q(cfg_run_q_b), .cfg_mask_q(cfg_mask_q_b),
        .ld_hi_wr(1'b0), .ld_hi_data('0), .ld_lo_wr(1'b0), .ld_lo_data('0),
        .load_go(1'b0), .upd_go(1'b0),
        .snap_valid(snap_valid_b), .snap_hi(snap_hi_b), .snap_lo(snap_lo_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the expected count when a snapshot becomes valid
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst && snap_valid && !prev_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected snapshot", 64'(snap_valid), 64'd0);
            end else begin
                cnt_t e;
                e = exp_q.pop_front();
                check("R8 snapshot value", 64'({snap_hi, snap_lo}), 64'(e));
            end
        end
        prev_valid <= snap_valid;
    end

    task automatic take_snap(input string req);
        @(negedge clk);
        upd_go = 1'b1;
        exp_q.push_back(exp_cnt);
        @(negedge clk);
        upd_go = 1'b0;
        check({"R8 valid cleared ", req}, 64'(snap_valid), 64'd0);
        @(negedge clk);
        check({"R8 valid set ", req}, 64'(snap_valid), 64'd1);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic write_cfg(input logic run, input logic [NCORE-1:0] mask);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_run_in = run; cfg_mask_in = mask;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_pre(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo);
        @(negedge clk);
        ld_hi_wr = 1'b1; ld_hi_data = hi;
        @(negedge clk);
        ld_hi_wr = 1'b0; ld_lo_wr = 1'b1; ld_lo_data = lo;
        @(negedge clk);
        ld_lo_wr = 1'b0;
    endtask

    task automatic pulse_load(input bit with_tick);
        @(negedge clk);
        load_go = 1'b1; tick_en = with_tick;
        @(negedge clk);
        load_go = 1'b0; tick_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 64'(snap_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", 64'(snap_valid), 64'd0);
        check("R1 snapshot words", 64'({snap_hi, snap_lo}), 64'd0);
        check("R1 unit0 run", 64'(cfg_run_q), 64'd1);
        check("R1 unit0 mask", 64'(cfg_mask_q), 64'd0);
        check("R1 unit1 run", 64'(cfg_run_q_b), 64'd0);
        check("R1 unit1 mask", 64'(cfg_mask_q_b), 64'd3);
        check("R1 unit1 valid", 64'(snap_valid_b), 64'd0);

        take_snap("R1 count zero");

        run_ticks(10); exp_cnt = 10;
        take_snap("R2 ten ticks");
        repeat (4) @(negedge clk);
        check("R8 snapshot held", 64'({snap_hi, snap_lo}), 64'd10);

        repeat (6) @(negedge clk);
        take_snap("R3 idle hold");

        write_cfg(1'b0, 2'b00);
        run_ticks(7);
        take_snap("R4 run off");
        write_cfg(1'b1, 2'b00);

        core_stall = 2'b01;
        run_ticks(4); exp_cnt += 4;
        take_snap("R5 unmasked stall");
        write_cfg(1'b1, 2'b01);
        run_ticks(6);
        take_snap("R5 masked stall");
        core_stall = 2'b10;
        run_ticks(3); exp_cnt += 3;
        take_snap("R5 other core unmasked");
        write_cfg(1'b1, 2'b10);
        run_ticks(5);
        take_snap("R5 core1 masked");
        core_stall = 2'b00;
        run_ticks(2); exp_cnt += 2;
        take_snap("R2 after stalls");

        write_pre(20'hABCDE, 32'h1234_5678);
        take_snap("R6 preload only");
        pulse_load(1'b0); exp_cnt = 52'hABCDE_1234_5678;
        take_snap("R7 load applied");

        write_pre(20'h00042, 32'h0000_0100);
        pulse_load(1'b1); exp_cnt = 52'h00042_0000_0100;
        take_snap("R7 load beats tick");

        write_pre(20'h00000, 32'hFFFF_FFFF);
        pulse_load(1'b0);
        run_ticks(1); exp_cnt = 52'h00001_0000_0000;
        take_snap("R9 word carry");

        write_pre(20'hFFFFF, 32'hFFFF_FFFE);
        pulse_load(1'b0);
        run_ticks(2); exp_cnt = '0;
        take_snap("R9 full wrap");

        repeat (3) @(negedge clk);
        check("R8 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule